// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit collects the event and error reports of an SD/MMC host controller into two sticky status words. Each word has a mask register beside it, and the unit drives a single interrupt line. Pulses from the command engine, the data engine and the error detectors set flag bits. Software clears flags bit by bit by writing zeros. Before each new command, software typically writes an all-zero word to each status register to clear everything.

Three of the reported bits are not latched flags. They are live views of the card-detect, command-busy and DAT0 levels. The buffer-ready flags and the card insert and remove flags come from level inputs through an edge detector. A flag therefore appears once per transition of its level and is not held while the level stays asserted. Software can clear a buffer-ready flag and then drain the buffer, and the flag does not come back for that same block. The first level sampled after reset is taken as the baseline, so a card that is already present at reset does not produce an insert event.

All state is reset by an asynchronous active-low reset that is released through a two-stage synchronizer. The first clock edge that updates state is therefore the third edge after `rst_n` rises.

Top module: `sd_irq_status`

## Requirements
- R1: Status word A (reg_addr 0) latches response-done in bit 0 from `ev_rsp_done` and transfer-done in bit 2 from `ev_xfer_done`; a one-cycle pulse sets the bit from the next clock edge on.
- R2: Status word B (reg_addr 1) latches `ev_err[6:0]` into bits 6..0 (index, CRC, end-bit, data timeout, illegal write, illegal read, response timeout) and `ev_err[7]` (illegal access) into bit 15.
- R3: Word B bit 8 sets on a rising edge of `rbuf_avail` and bit 9 on a rising edge of `wbuf_empty`; a flag cleared while its level stays high does not set again until the level falls and rises.
- R4: Word A bit 4 latches on a rising edge of `card_det` and bit 3 on a falling edge; bit 5 always reads the current `card_det` level; the first level after reset is a baseline and raises no flag.
- R5: Word B bit 7 reads `dat0_lvl` and bit 14 reads `cmd_busy` live, and writes to word B do not change them.
- R6: A write to a status word clears each latched flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R7: When a set event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R8: Mask registers for word A (reg_addr 2) and word B (reg_addr 3) are 16 bits, read back what was written, and reset to 16'hFFFF.
- R9: `irq` is high one cycle after any latched flag is set with its mask bit 0, and low one cycle after no such flag remains; a mask bit of 1 blocks its flag.
- R10: Reset clears every latched flag and `irq`; bits that are neither latched nor live always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write: 0 word A, 1 word B, 2 mask A, 3 mask B |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| ev_rsp_done | input | 1 | Response-complete pulse |
| ev_xfer_done | input | 1 | Data-transfer-complete pulse |
| ev_err | input | 8 | Error pulses; bits 6..0 map to word B bits 6..0, bit 7 to word B bit 15 |
| rbuf_avail | input | 1 | Level: a read block is ready in the buffer |
| wbuf_empty | input | 1 | Level: the write buffer is empty |
| card_det | input | 1 | Card-detect level |
| cmd_busy | input | 1 | Command-busy level |
| dat0_lvl | input | 1 | DAT0 line level |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag can receive a set event and a software clear in the same cycle. The bench provokes this by pulsing `ev_xfer_done` in the same cycle that a zero is written to word A, and also inside a random phase where event pulses and writes overlap freely. A cycle-by-cycle behavioural model applies the clear first and the set after it, and the read value and `irq` are compared with it on every clock. A second overlap happens when a write to word B arrives while DAT0 or busy is high; there the live bits must still show their inputs afterwards.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int STAT_W = 16;
  localparam int ERR_N  = 8;
  localparam int ERR_LO = ERR_N - 1;
  localparam int LVL_N  = 3;

  // word A bit positions
  localparam int A_RSP    = 0;
  localparam int A_XFER   = 2;
  localparam int A_REMOVE = 3;
  localparam int A_INSERT = 4;
  localparam int A_CD     = 5;
  // word B bit positions
  localparam int B_DAT0   = 7;
  localparam int B_RBUF   = 8;
  localparam int B_WBUF   = 9;
  localparam int B_BUSY   = 14;
  localparam int B_ILA    = 15;

  localparam logic [STAT_W-1:0] A_LATCH = 16'h001D;
  localparam logic [STAT_W-1:0] B_LATCH = 16'h837F;

  // edge detector lane order
  localparam int LN_RBUF = 0;
  localparam int LN_WBUF = 1;
  localparam int LN_CD   = 2;

  typedef enum logic [1:0] {
    SEL_STAT_A = 2'd0,
    SEL_STAT_B = 2'd1,
    SEL_MASK_A = 2'd2,
    SEL_MASK_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sd_irq_edge.sv
module sd_irq_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q, prev_d;
  logic         primed_q, primed_d;

  always_comb begin
    prev_d   = lvl;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  assign chg = {N{primed_q}} & (lvl ^ prev_q);
endmodule

// File: rtl/sd_irq_word.sv
module sd_irq_word #(
  parameter int               W     = 16,
  parameter logic [W-1:0]     LATCH = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q, flags_d;
  logic         upd_en;

  always_comb begin
    flags_d = flags_q;
    if (clr_we)
      flags_d = flags_d & clr_data;
    flags_d = (flags_d | set) & LATCH;
  end

  assign upd_en = clr_we | (|(set & LATCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (upd_en)
      flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/sd_irq_mask.sv
module sd_irq_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q, mask_d;

  always_comb mask_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (we)
      mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sd_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [STAT_W-1:0]   reg_wdata,
  output logic [STAT_W-1:0]   reg_rdata,
  input  logic                ev_rsp_done,
  input  logic                ev_xfer_done,
  input  logic [ERR_N-1:0]    ev_err,
  input  logic                rbuf_avail,
  input  logic                wbuf_empty,
  input  logic                card_det,
  input  logic                cmd_busy,
  input  logic                dat0_lvl,
  output logic                irq
);
  logic [1:0]        rsync_q;
  logic              rst_sync_n;
  logic [LVL_N-1:0]  lvl, chg;
  logic [STAT_W-1:0] set_a, set_b, st_a, st_b, mk_a, mk_b;
  logic              we_sa, we_sb, we_ma, we_mb;
  logic              irq_q, irq_d;
  reg_sel_e          sel;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= '0;
    else
      rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign sel   = reg_sel_e'(reg_addr);
  assign we_sa = reg_we && (sel == SEL_STAT_A);
  assign we_sb = reg_we && (sel == SEL_STAT_B);
  assign we_ma = reg_we && (sel == SEL_MASK_A);
  assign we_mb = reg_we && (sel == SEL_MASK_B);

  always_comb begin
    lvl          = '0;
    lvl[LN_RBUF] = rbuf_avail;
    lvl[LN_WBUF] = wbuf_empty;
    lvl[LN_CD]   = card_det;
  end

  sd_irq_edge #(.N(LVL_N)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(lvl), .chg(chg)
  );

  always_comb begin
    set_a           = '0;
    set_a[A_RSP]    = ev_rsp_done;
    set_a[A_XFER]   = ev_xfer_done;
    set_a[A_INSERT] = chg[LN_CD] & card_det;
    set_a[A_REMOVE] = chg[LN_CD] & ~card_det;
  end

  always_comb begin
    set_b = '0;
    for (int i = 0; i < ERR_LO; i++)
      set_b[i] = ev_err[i];
    set_b[B_ILA]  = ev_err[ERR_N-1];
    set_b[B_RBUF] = chg[LN_RBUF] & rbuf_avail;
    set_b[B_WBUF] = chg[LN_WBUF] & wbuf_empty;
  end

  sd_irq_word #(.W(STAT_W), .LATCH(A_LATCH)) u_word_a (
    .clk(clk), .rst_n(rst_sync_n), .set(set_a),
    .clr_we(we_sa), .clr_data(reg_wdata), .flags(st_a)
  );

  sd_irq_word #(.W(STAT_W), .LATCH(B_LATCH)) u_word_b (
    .clk(clk), .rst_n(rst_sync_n), .set(set_b),
    .clr_we(we_sb), .clr_data(reg_wdata), .flags(st_b)
  );

  sd_irq_mask #(.W(STAT_W)) u_mask_a (
    .clk(clk), .rst_n(rst_sync_n), .we(we_ma), .wdata(reg_wdata), .mask(mk_a)
  );

  sd_irq_mask #(.W(STAT_W)) u_mask_b (
    .clk(clk), .rst_n(rst_sync_n), .we(we_mb), .wdata(reg_wdata), .mask(mk_b)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT_A: begin
        reg_rdata       = st_a;
        reg_rdata[A_CD] = card_det;
      end
      SEL_STAT_B: begin
        reg_rdata         = st_b;
        reg_rdata[B_DAT0] = dat0_lvl;
        reg_rdata[B_BUSY] = cmd_busy;
      end
      SEL_MASK_A: reg_rdata = mk_a;
      default:    reg_rdata = mk_b;
    endcase
  end

  always_comb irq_d = (|(st_a & ~mk_a)) | (|(st_b & ~mk_b));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      irq_q <= 1'b0;
    else
      irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/sd_irq_status_chk.sv
module sd_irq_status_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        ev_rsp_done,
  input logic        ev_xfer_done,
  input logic        wbuf_empty,
  input logic        dat0_lvl,
  input logic        cmd_busy,
  input logic        irq,
  input logic [15:0] st_a,
  input logic [15:0] st_b,
  input logic [15:0] mk_a,
  input logic [15:0] mk_b
);
  // R1
  a_r1_rsp_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_rsp_done |=> st_a[0]);

  // R7
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_xfer_done && reg_we && reg_addr == 2'd0 && !reg_wdata[2]) |=> st_a[2]);

  // R6
  a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && reg_addr == 2'd1 && reg_wdata[15] && st_b[15]) |=> st_b[15]);

  a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && reg_addr == 2'd0 && !reg_wdata[0] && !ev_rsp_done) |=> !st_a[0]);

  // R3
  a_r3_no_reassert: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wbuf_empty && $past(wbuf_empty) && reg_we && reg_addr == 2'd1 && !reg_wdata[9])
    |=> !st_b[9]);

  // R5
  a_r5_live_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == 2'd1) |-> (reg_rdata[7] == dat0_lvl && reg_rdata[14] == cmd_busy));

  // R9
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|(st_a & ~mk_a)) || (|(st_b & ~mk_b))) |=> irq);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((|(st_a & ~mk_a)) || (|(st_b & ~mk_b))) |=> !irq);
endmodule

bind sd_irq_status sd_irq_status_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rsp_done(ev_rsp_done),
  .ev_xfer_done(ev_xfer_done), .wbuf_empty(wbuf_empty), .dat0_lvl(dat0_lvl),
  .cmd_busy(cmd_busy), .irq(irq), .st_a(st_a), .st_b(st_b), .mk_a(mk_a), .mk_b(mk_b)
);

// File: tb/tb_sd_irq_status.sv
module tb_sd_irq_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ev_rsp_done, ev_xfer_done;
  logic [7:0]  ev_err;
  logic        rbuf_avail, wbuf_empty, card_det, cmd_busy, dat0_lvl;
  logic        irq;

  always #10 clk = ~clk;

  sd_irq_status dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rsp_done(ev_rsp_done),
    .ev_xfer_done(ev_xfer_done), .ev_err(ev_err), .rbuf_avail(rbuf_avail),
    .wbuf_empty(wbuf_empty), .card_det(card_det), .cmd_busy(cmd_busy),
    .dat0_lvl(dat0_lvl), .irq(irq)
  );

  localparam logic [15:0] LA = 16'h001D;
  localparam logic [15:0] LB = 16'h837F;

  int    total = 0;
  int    bad   = 0;
  bit    cmp_on = 0;
  bit    done   = 0;
  string cur_tag = "R10";

  // behavioural reference state
  logic [15:0] mf_a = '0, mf_b = '0, mm_a = '1, mm_b = '1;
  logic        m_irq = 1'b0, p_rb = 1'b0, p_wb = 1'b0, p_cd = 1'b0, primed = 1'b0;
  int          rcnt = 0;

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] sa, sb;
    logic        nirq;
    if (!rst_n) begin
      rcnt = 0; mf_a = '0; mf_b = '0; mm_a = '1; mm_b = '1;
      m_irq = 1'b0; primed = 1'b0; p_rb = 1'b0; p_wb = 1'b0; p_cd = 1'b0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      nirq = (|(mf_a & ~mm_a)) || (|(mf_b & ~mm_b));
      sa = '0; sb = '0;
      sa[0] = ev_rsp_done;
      sa[2] = ev_xfer_done;
      sb[6:0] = ev_err[6:0];
      sb[15]  = ev_err[7];
      if (primed) begin
        sa[4] = card_det & ~p_cd;
        sa[3] = ~card_det & p_cd;
        sb[8] = rbuf_avail & ~p_rb;
        sb[9] = wbuf_empty & ~p_wb;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: mf_a = mf_a & reg_wdata;
          2'd1: mf_b = mf_b & reg_wdata;
          2'd2: mm_a = reg_wdata;
          default: mm_b = reg_wdata;
        endcase
      end
      mf_a = (mf_a | sa) & LA;
      mf_b = (mf_b | sb) & LB;
      p_rb = rbuf_avail; p_wb = wbuf_empty; p_cd = card_det; primed = 1'b1;
      m_irq = nirq;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] v;
    case (a)
      2'd0: begin v = mf_a; v[5] = card_det; end
      2'd1: begin v = mf_b; v[7] = dat0_lvl; v[14] = cmd_busy; end
      2'd2: v = mm_a;
      default: v = mm_b;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_tag, reg_rdata, exp_rd(reg_addr));
      chk("R9", {15'd0, irq}, {15'd0, m_irq});
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic quiet();
    reg_we = 1'b0; ev_rsp_done = 1'b0; ev_xfer_done = 1'b0; ev_err = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  // sample at the next negedge
  task automatic look(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    rbuf_avail = 0; wbuf_empty = 0; card_det = 0; cmd_busy = 0; dat0_lvl = 0;
    quiet();
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1;

    // R10 / R8 reset state
    look("R10", 2'd0, 16'h0000);
    look("R10", 2'd1, 16'h0000);
    look("R8", 2'd2, 16'hFFFF);
    look("R8", 2'd3, 16'hFFFF);
    chk("R10", {15'd0, irq}, 16'd0);

    // R1
    cur_tag = "R1";
    ev_rsp_done = 1; tick(); ev_rsp_done = 0;
    look("R1", 2'd0, 16'h0001);
    ev_xfer_done = 1; tick(); ev_xfer_done = 0;
    look("R1", 2'd0, 16'h0005);

    // R6 per-bit clear
    cur_tag = "R6";
    wr(2'd0, 16'hFFFE);
    look("R6", 2'd0, 16'h0004);
    wr(2'd0, 16'h0000);
    look("R6", 2'd0, 16'h0000);

    // R2
    cur_tag = "R2";
    ev_err = 8'hFF; tick(); ev_err = '0;
    look("R2", 2'd1, 16'h807F);

    // R9 unmask then mask again
    cur_tag = "R9";
    wr(2'd3, 16'hFFFE);
    tick();
    chk("R9", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'hFFFF);
    tick();
    chk("R9", {15'd0, irq}, 16'd0);
    look("R8", 2'd3, 16'hFFFF);
    wr(2'd1, 16'h0000);

    // R3 edge-only buffer flags
    cur_tag = "R3";
    rbuf_avail = 1; tick();
    look("R3", 2'd1, 16'h0100);
    wr(2'd1, 16'h0000);
    tick();
    look("R3", 2'd1, 16'h0000);
    rbuf_avail = 0; tick(); rbuf_avail = 1; tick();
    look("R3", 2'd1, 16'h0100);
    wbuf_empty = 1; tick();
    wr(2'd1, 16'hFEFF);
    look("R3", 2'd1, 16'h0200);
    wr(2'd1, 16'h0000);
    tick();
    look("R3", 2'd1, 16'h0000);
    rbuf_avail = 0; wbuf_empty = 0;

    // R4 card detect
    cur_tag = "R4";
    card_det = 1; tick();
    look("R4", 2'd0, 16'h0030);
    card_det = 0; tick();
    look("R4", 2'd0, 16'h0018);
    wr(2'd0, 16'h0000);

    // R5 live bits survive writes
    cur_tag = "R5";
    dat0_lvl = 1; cmd_busy = 1;
    wr(2'd1, 16'h0000);
    look("R5", 2'd1, 16'h4080);
    dat0_lvl = 0;
    look("R5", 2'd1, 16'h4000);
    cmd_busy = 0;

    // R7 set and clear collide
    cur_tag = "R7";
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 16'h0000; ev_xfer_done = 1;
    tick();
    quiet();
    look("R7", 2'd0, 16'h0004);
    wr(2'd0, 16'h0000);

    // R10 mid-run reset, R4 baseline with card present
    cur_tag = "R10";
    wr(2'd2, 16'h0000);
    ev_rsp_done = 1; card_det = 1; tick(); ev_rsp_done = 0;
    tick();
    rst_n = 0;
    @(negedge clk);
    chk("R10", {15'd0, irq}, 16'd0);
    look("R10", 2'd0, 16'h0020);
    rst_n = 1;
    repeat (4) tick();
    look("R4", 2'd0, 16'h0020);
    look("R8", 2'd2, 16'hFFFF);

    // random overlap phase
    cur_tag = "R6";
    for (int n = 0; n < 400; n++) begin
      reg_we       = ($urandom % 4) == 0;
      reg_addr     = 2'($urandom % 4);
      reg_wdata    = 16'($urandom);
      ev_rsp_done  = ($urandom % 5) == 0;
      ev_xfer_done = ($urandom % 5) == 0;
      ev_err       = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      rbuf_avail   = ($urandom % 3) == 0 ? ~rbuf_avail : rbuf_avail;
      wbuf_empty   = ($urandom % 3) == 0 ? ~wbuf_empty : wbuf_empty;
      card_det     = ($urandom % 7) == 0 ? ~card_det : card_det;
      cmd_busy     = 1'($urandom);
      dat0_lvl     = 1'($urandom);
      tick();
    end
    quiet();
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule